// File: doc/BRIEF.md
# Instruction Fetch Cache with Saturating Profiling Counters

This block sits between a processor's instruction-fetch port and a slow flash read port. It keeps 2048 bytes of recently fetched code in a direct-mapped array of 16-byte lines. A fetch that hits is answered in the cycle it is presented. A fetch that misses goes to the flash port, which returns a whole line after a latency set by the flash side. That line is written into the array and the requested word is returned in the same cycle. Only one flash request is outstanding at any time.

Software controls the block through a small register window. A configuration register holds a cache-enable bit and a profiling-enable bit. Two counters, one for hits and one for misses, can be read and written. They stop at all-ones instead of wrapping. Clearing the enable bit empties the cache. While the flash controller's access mode is program or erase, every line is held invalid, so stale code can never be served from the cache while flash contents are changing.

Top module: `icache_prof`

## Requirements
- R1: After reset the configuration register reads 0, both counters read 0 and no flash request is active.
- R2: With the cache enabled and the access mode read-only (`mem_mode` = 0), a fetch to a line already held completes in the cycle it is presented (zero wait cycles) with the word stored at that address.
- R3: A miss raises `fl_req` in the next cycle with a line-aligned `fl_addr` (the low 4 bits zero) and holds both until `fl_ack`. The fetch then completes in the `fl_ack` cycle with the addressed word taken from `fl_line`, where word k of the line is `fl_line[32k+31:32k]`.
- R4: While the enable bit is 0, every fetch goes to the flash port, even when it repeats an address. Neither counter changes, whatever the profiling bit is set to.
- R5: Writing the enable bit to 0 invalidates every line, so after it is enabled again a previously held line misses.
- R6: While `mem_mode` is 1 (program) or 2 (erase), every fetch misses and nothing is filled. After the mode returns to 0, the first fetch to a line misses and the next one hits.
- R7: While the profiling bit is 1 and the cache is enabled, the hit counter goes up by one per hit and the miss counter by one per miss. While the profiling bit is 0 they hold.
- R8: Both counters take software writes and stop at 0xFFFFFFFF instead of wrapping.
- R9: The cache is direct-mapped. Two addresses 2048 bytes apart share a line and evict each other.
- R10: The register window is selected by `reg_addr`: 0 is configuration (bit 0 enable, bit 8 profiling, other bits read 0), 1 is the hit counter and 2 is the miss counter. A write takes effect when `reg_wr` is high at a clock edge, and `reg_rdata` shows the selected register at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch request valid |
| f_addr | input | 32 | Fetch byte address, word aligned, held until accepted |
| f_ready | output | 1 | Fetch accepted; f_data valid |
| f_data | output | 32 | Fetched instruction word |
| fl_req | output | 1 | Flash line read request |
| fl_addr | output | 32 | Line-aligned flash address |
| fl_ack | input | 1 | Flash line returned |
| fl_line | input | 128 | Flash line data |
| mem_mode | input | 2 | Flash access mode: 0 read, 1 program, 2 erase |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |

## Verification
The bench builds the block with its default geometry: 2048 bytes in 128 lines of 16 bytes. Its flash model answers three cycles after a request is raised, so a miss costs exactly four wait cycles and a hit costs none. Every fetch therefore shows directly whether it hit or missed. With the default geometry, addresses 2048 bytes apart land on the same line, which makes eviction visible. Because the counters can be written, the bench can preload them one step below all-ones and reach saturation in two fetches instead of four billion.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2
  } mem_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fetch_state_e;

  localparam int CNT_W        = 32;
  localparam int WORD_W       = 32;
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_HIT  = 2'd1;
  localparam logic [1:0] SEL_MISS = 2'd2;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_PROF_BIT = 8;
endpackage

// File: rtl/icache_satcnt.sv
module icache_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)
      cnt_d = wdata_i;
    else if (inc_i && (cnt_q != {W{1'b1}}))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (wr_i || inc_i)
      cnt_q <= cnt_d;
  end

  assign q_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {W{1'b1}} && !wr_i) |=> (cnt_q == {W{1'b1}})); // R8

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !inc_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int LINES     = 128,
  parameter int TAG_W     = 21,
  parameter int LINE_BITS = 128,
  localparam int IDX_W    = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 allow_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic                 fill_i,
  input  logic [LINE_BITS-1:0] fill_line_i,
  output logic                 hit_o,
  output logic [LINE_BITS-1:0] line_o
);
  logic [LINES-1:0]     valid_q, valid_d;
  logic [TAG_W-1:0]     tag_q  [LINES];
  logic [LINE_BITS-1:0] data_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (!allow_i)
      valid_d = '0;
    else if (fill_i)
      valid_d[idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else
      valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_i && allow_i) begin
      tag_q[idx_i]  <= tag_i;
      data_q[idx_i] <= fill_line_i;
    end
  end

  assign hit_o  = valid_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign line_o = data_q[idx_i];

  AST_HELD_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !allow_i |=> (valid_q == '0)); // R6
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic f_valid_i,
  input  logic hit_i,
  input  logic allow_i,
  input  logic fl_ack_i,
  output logic f_ready_o,
  output logic fl_req_o,
  output logic use_flash_o,
  output logic fill_o,
  output logic hit_done_o,
  output logic miss_done_o
);
  fetch_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    f_ready_o   = 1'b0;
    use_flash_o = 1'b0;
    fill_o      = 1'b0;
    hit_done_o  = 1'b0;
    miss_done_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (f_valid_i) begin
          if (hit_i && allow_i) begin
            f_ready_o  = 1'b1;
            hit_done_o = 1'b1;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (fl_ack_i) begin
          f_ready_o   = 1'b1;
          use_flash_o = 1'b1;
          fill_o      = allow_i;
          miss_done_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

  assign fl_req_o = (state_q == ST_FILL);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req_o && !fl_ack_i) |=> fl_req_o); // R3

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req_o && fl_ack_i) |=> !fl_req_o); // R3

  AST_FILL_ON_MISS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o |-> (fl_ack_i && allow_i)); // R6
endmodule

// File: rtl/icache_prof.sv
module icache_prof
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES = 16,
  localparam int LINES     = CACHE_BYTES / LINE_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int WSEL_W    = OFF_W - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 f_valid,
  input  logic [ADDR_W-1:0]    f_addr,
  output logic                 f_ready,
  output logic [31:0]          f_data,
  output logic                 fl_req,
  output logic [ADDR_W-1:0]    fl_addr,
  input  logic                 fl_ack,
  input  logic [LINE_BITS-1:0] fl_line,
  input  logic [1:0]           mem_mode,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata
);
  logic                 cfg_en_q, cfg_prof_q;
  logic                 cfg_wr;
  logic                 allow;
  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     tag;
  logic [WSEL_W-1:0]    wsel;
  logic                 hit, fill, use_flash, hit_done, miss_done;
  logic [LINE_BITS-1:0] hit_line, src_line;
  logic [CNT_W-1:0]     hit_cnt, miss_cnt;
  logic                 unused_low;

  assign unused_low = ^f_addr[1:0];
  assign idx  = f_addr[OFF_W +: IDX_W];
  assign tag  = f_addr[ADDR_W-1 -: TAG_W];
  assign wsel = f_addr[2 +: WSEL_W];

  assign cfg_wr = reg_wr && (reg_addr == SEL_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q   <= 1'b0;
      cfg_prof_q <= 1'b0;
    end else if (cfg_wr) begin
      cfg_en_q   <= reg_wdata[CFG_EN_BIT];
      cfg_prof_q <= reg_wdata[CFG_PROF_BIT];
    end
  end

  assign allow = cfg_en_q && (mem_mode_e'(mem_mode) == MODE_READ);

  icache_store #(
    .LINES(LINES), .TAG_W(TAG_W), .LINE_BITS(LINE_BITS)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .allow_i(allow),
    .idx_i(idx), .tag_i(tag),
    .fill_i(fill), .fill_line_i(fl_line),
    .hit_o(hit), .line_o(hit_line)
  );

  icache_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .f_valid_i(f_valid), .hit_i(hit), .allow_i(allow), .fl_ack_i(fl_ack),
    .f_ready_o(f_ready), .fl_req_o(fl_req), .use_flash_o(use_flash),
    .fill_o(fill), .hit_done_o(hit_done), .miss_done_o(miss_done)
  );

  assign fl_addr  = {f_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign src_line = use_flash ? fl_line : hit_line;
  assign f_data   = src_line[wsel*WORD_W +: WORD_W];

  icache_satcnt #(.W(CNT_W)) u_hits (
    .clk(clk), .rst_n(rst_n),
    .inc_i(hit_done && cfg_en_q && cfg_prof_q),
    .wr_i(reg_wr && (reg_addr == SEL_HIT)),
    .wdata_i(reg_wdata), .q_o(hit_cnt)
  );

  icache_satcnt #(.W(CNT_W)) u_misses (
    .clk(clk), .rst_n(rst_n),
    .inc_i(miss_done && cfg_en_q && cfg_prof_q),
    .wr_i(reg_wr && (reg_addr == SEL_MISS)),
    .wdata_i(reg_wdata), .q_o(miss_cnt)
  );

  always_comb begin
    unique case (reg_addr)
      SEL_CFG: begin
        reg_rdata = '0;
        reg_rdata[CFG_EN_BIT]   = cfg_en_q;
        reg_rdata[CFG_PROF_BIT] = cfg_prof_q;
      end
      SEL_HIT:  reg_rdata = hit_cnt;
      SEL_MISS: reg_rdata = miss_cnt;
      default:  reg_rdata = '0;
    endcase
  end

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en_q && !reg_wr) |=> ($stable(hit_cnt) && $stable(miss_cnt))); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> $stable(fl_addr)); // R3

  AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_ready && !cfg_en_q) |-> use_flash); // R4
endmodule

// File: tb/tb_icache_prof.sv
`timescale 1ns/1ps
module tb_icache_prof;
  localparam int FL_LAT    = 3;
  localparam int MISS_WAIT = FL_LAT + 1;

  logic         clk, rst_n;
  logic         f_valid, f_ready;
  logic [31:0]  f_addr, f_data;
  logic         fl_req, fl_ack;
  logic [31:0]  fl_addr;
  logic [127:0] fl_line;
  logic [1:0]   mem_mode;
  logic         reg_wr;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] data;
    int          waits;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  int   wait_cnt = 0;
  logic hs_seen  = 0;
  int   fcnt;

  icache_prof dut (
    .clk(clk), .rst_n(rst_n),
    .f_valid(f_valid), .f_addr(f_addr), .f_ready(f_ready), .f_data(f_data),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_line(fl_line),
    .mem_mode(mem_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [31:0] word_at(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0F0F;
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++)
      fl_line[k*32 +: 32] = word_at(fl_addr + 32'(k*4));
  end

  assign fl_ack = fl_req && (fcnt == FL_LAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fcnt <= 0;
    else if (fl_ack) fcnt <= 0;
    else if (fl_req) fcnt <= fcnt + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each completed fetch
  always @(negedge clk) begin
    if (rst_n && f_valid) begin
      if (fl_req) check("R3 aligned fl_addr", fl_addr, f_addr & 32'hFFFF_FFF0);
      if (f_ready) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          check("scoreboard empty", 32'd1, 32'd0);
        end else begin
          e = sb_q.pop_front();
          check({e.req, " data"}, f_data, e.data);
          check({e.req, " wait cycles"}, 32'(wait_cnt), 32'(e.waits));
        end
        wait_cnt = 0;
        hs_seen  = 1;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic fetch(logic [31:0] a, int waits, string req);
    exp_t e;
    e.data = word_at(a); e.waits = waits; e.req = req;
    sb_q.push_back(e);
    @(posedge clk); #1;
    hs_seen = 0;
    f_valid = 1; f_addr = a;
    @(posedge clk);
    while (!hs_seen) @(posedge clk);
    #1 f_valid = 0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(posedge clk); #1 mem_mode = m;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [31:0] A = 32'h0000_0100;
  localparam logic [31:0] B = 32'h0000_0400;

  initial begin
    rst_n = 0; f_valid = 0; f_addr = 0; mem_mode = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd_reg(2'd0, 32'h0, "R1 cfg reset");
    rd_reg(2'd1, 32'h0, "R1 hit reset");
    rd_reg(2'd2, 32'h0, "R1 miss reset");
    check("R1 no request", 32'(fl_req), 32'd0);

    // disabled, profiling on: everything goes to flash, no counting
    wr_reg(2'd0, 32'h0000_0100);
    fetch(A, MISS_WAIT, "R4 disabled first");
    fetch(A, MISS_WAIT, "R4 disabled repeat");
    rd_reg(2'd1, 32'h0, "R4 hit frozen");
    rd_reg(2'd2, 32'h0, "R4 miss frozen");

    // enable with profiling
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, 32'h0000_0101, "R10 cfg readback");
    fetch(A,       MISS_WAIT, "R3 miss fill");
    fetch(A + 4,   0,         "R2 hit word1");
    fetch(A + 12,  0,         "R2 hit word3");
    rd_reg(2'd1, 32'd2, "R7 hits");
    rd_reg(2'd2, 32'd1, "R7 misses");

    // conflict
    fetch(A + 2048, MISS_WAIT, "R9 conflict miss");
    fetch(A,        MISS_WAIT, "R9 evicted");

    // profiling off
    wr_reg(2'd0, 32'h0000_0001);
    fetch(A, 0, "R7 hit prof off");
    rd_reg(2'd1, 32'd2, "R7 hits held");

    // disable then re-enable invalidates
    wr_reg(2'd0, 32'h0000_0000);
    wr_reg(2'd0, 32'h0000_0101);
    fetch(A, MISS_WAIT, "R5 after re-enable");

    // program / erase modes
    set_mode(2'd1);
    fetch(A, MISS_WAIT, "R6 program mode");
    fetch(A, MISS_WAIT, "R6 program mode repeat");
    set_mode(2'd2);
    fetch(A, MISS_WAIT, "R6 erase mode");
    set_mode(2'd0);
    fetch(A, MISS_WAIT, "R6 back to read");
    fetch(A, 0,         "R6 hit after return");
    rd_reg(2'd1, 32'd3, "R7 hits total");
    rd_reg(2'd2, 32'd8, "R7 misses total");

    // saturation
    wr_reg(2'd1, 32'hFFFF_FFFE);
    rd_reg(2'd1, 32'hFFFF_FFFE, "R10 hit write");
    fetch(A + 8, 0, "R8 hit near top");
    fetch(A + 8, 0, "R8 hit at top");
    rd_reg(2'd1, 32'hFFFF_FFFF, "R8 hit saturates");
    wr_reg(2'd2, 32'hFFFF_FFFF);
    fetch(B, MISS_WAIT, "R8 miss at top");
    rd_reg(2'd2, 32'hFFFF_FFFF, "R8 miss saturates");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule